// File: doc/BRIEF.md
# Pipelined Booth Multiplier with Redundant Product Output

This block multiplies two signed two's-complement operands of `OPW` bits each (16 by default). It leaves the product in carry-save form: two `2*OPW`-bit vectors whose modular sum is the exact product. A following stage, typically an accumulator in a filter tap chain, can keep adding in redundant form and pay for a single carry-propagate addition at the very end. One operand pair can be offered on every clock. A qualifying flag travels beside the data, so the consumer knows which output cycles carry a result.

Internally the multiplier operand is recoded into signed radix-4 digits, which halves the number of partial products. Each partial product is a selected multiple of the multiplicand, sign-extended to the full product width. A negative digit inverts that multiple and adds a one at the multiple's lowest weight. These injected ones are gathered into one extra row. A tree of 3:2 carry-save compressors reduces all rows to two. Registers sit after partial-product generation, between the two halves of the compressor tree, and at the output. For checking and debug, a resolved product is also provided, computed from the registered sum and carry.

Top module: `booth_csa_mul`

## Requirements
- R1: When `out_valid` is high, `(out_sum + out_carry) mod 2^(2*OPW)` equals the exact signed product of the operands presented with the corresponding `in_valid`.
- R2: Every cycle with `in_valid` high yields exactly one cycle with `out_valid` high, three clocks later. A cycle with `in_valid` low yields `out_valid` low three clocks later.
- R3: Operand pairs offered on consecutive clocks are all accepted, with no stall. Their results appear on consecutive clocks in the same order.
- R4: While `rst` is high, and during the three clocks after it falls, `out_valid` is low. Any `in_valid` seen while `rst` is high is dropped.
- R5: The product is correct for multipliers containing any mix of Booth digit cases. Bit triplets 000/111 mean digit 0, 001/010 mean +1, 011 means +2, 100 means -2, and 101/110 mean -1. This includes alternating patterns and runs of ones.
- R6: The most negative value times itself (0x8000 × 0x8000 at 16 bits) gives the 32-bit result 0x40000000.
- R7: The most negative value times one gives 0xFFFF8000, which is the operand sign-extended to 32 bits.
- R8: When `out_valid` is high, `out_product` equals the exact signed product, truncated to `2*OPW` bits.
- R9: A zero operand on either side gives a redundant pair that sums to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; clears the valid pipeline |
| in_valid | input | 1 | Operand pair on `in_a`/`in_b` is to be multiplied |
| in_a | input | OPW | Multiplicand, two's complement |
| in_b | input | OPW | Multiplier (Booth recoded), two's complement |
| out_valid | output | 1 | `out_sum`/`out_carry` hold a result |
| out_sum | output | 2*OPW | Sum vector of the redundant product |
| out_carry | output | 2*OPW | Carry vector of the redundant product |
| out_product | output | 2*OPW | Resolved product `out_sum + out_carry`, for checking |

## Verification
The bench builds the block with its default `OPW = 16`. At that width the partial products and the correction row form nine rows. These need four compressor levels, split two and two across the middle register, so every pipeline stage and every path through the tree is exercised. At 16 bits the extreme corners can be written out exactly: the most negative square, the most negative value times one, and the all-ones and alternating multipliers. Long back-to-back runs and runs with gaps then compare each result and its arrival cycle against a queue of products computed in the bench.

// File: rtl/bcm_pkg.sv
package bcm_pkg;

    // One signed radix-4 digit: magnitude select plus sign
    typedef struct packed {
        logic neg;   // digit is negative
        logic one;   // magnitude 1
        logic two;   // magnitude 2
    } bdigit_t;

    // Recode bit triplet {b[2i+1], b[2i], b[2i-1]}
    function automatic bdigit_t recode(input logic [2:0] t);
        bdigit_t d;
        d = '0;
        case (t)
            3'b001, 3'b010: d.one = 1'b1;
            3'b011:         d.two = 1'b1;
            3'b100:         begin d.two = 1'b1; d.neg = 1'b1; end
            3'b101, 3'b110: begin d.one = 1'b1; d.neg = 1'b1; end
            default:        d = '0;
        endcase
        return d;
    endfunction

    // Rows left after one level of 3:2 compression
    function automatic int rows_after(input int n);
        return (n / 3) * 2 + (n % 3);
    endfunction

    // Rows left after lvl levels
    function automatic int rows_at(input int n, input int lvl);
        int r;
        r = n;
        for (int k = 0; k < lvl; k++) r = rows_after(r);
        return r;
    endfunction

    // Levels needed to reach two rows
    function automatic int levels_to_two(input int n);
        int r;
        int c;
        r = n;
        c = 0;
        for (int k = 0; k < 64; k++) begin
            if (r > 2) begin
                r = rows_after(r);
                c = c + 1;
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/csa32.sv
module csa32 #(
    parameter int W = 32
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] z,
    output logic [W-1:0] s,
    output logic [W-1:0] c
);
    assign s = x ^ y ^ z;
    // majority shifted up one weight; top carry falls off (mod 2^W)
    assign c[W-1:1] = (x[W-2:0] & y[W-2:0]) | (x[W-2:0] & z[W-2:0])
                    | (y[W-2:0] & z[W-2:0]);
    assign c[0] = 1'b0;
endmodule

// File: rtl/booth_pp_gen.sv
module booth_pp_gen
    import bcm_pkg::*;
#(
    parameter int OPW = 16
) (
    input  logic [OPW-1:0]               a,
    input  logic [OPW-1:0]               b,
    output logic [OPW/2:0][2*OPW-1:0]    rows
);
    localparam int PW  = 2 * OPW;
    localparam int NPP = OPW / 2;

    logic [PW-1:0]  a_ext;
    logic [NPP-1:0] neg_vec;

    assign a_ext = {{OPW{a[OPW-1]}}, a};

    for (genvar i = 0; i < NPP; i++) begin : g_pp
        logic [2:0]    trip;
        bdigit_t       dig;
        logic [PW-1:0] mult;
        logic [PW-1:0] mult_s;

        if (i == 0) begin : g_lsb
            assign trip = {b[1], b[0], 1'b0};
        end else begin : g_mid
            assign trip = b[2*i+1 : 2*i-1];
        end

        assign dig    = recode(trip);
        assign mult   = dig.two ? {a_ext[PW-2:0], 1'b0}
                      : dig.one ? a_ext : '0;
        assign mult_s = dig.neg ? ~mult : mult;
        assign rows[i]    = mult_s << (2 * i);
        assign neg_vec[i] = dig.neg;
    end

    // Row of +1 injections completing each negation
    always_comb begin
        rows[NPP] = '0;
        for (int k = 0; k < NPP; k++) rows[NPP][2*k] = neg_vec[k];
    end
endmodule

// File: rtl/csa_reduce.sv
module csa_reduce
    import bcm_pkg::*;
#(
    parameter int W      = 32,
    parameter int NIN    = 9,
    parameter int LEVELS = 2,
    localparam int NOUT  = rows_at(NIN, LEVELS)
) (
    input  logic [NIN-1:0][W-1:0]  rows_in,
    output logic [NOUT-1:0][W-1:0] rows_out
);
    logic [LEVELS:0][NIN-1:0][W-1:0] lv;

    assign lv[0] = rows_in;

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        localparam int N = rows_at(NIN, l);
        localparam int G = N / 3;
        localparam int R = N % 3;

        for (genvar g = 0; g < G; g++) begin : g_grp
            csa32 #(.W(W)) u_csa (
                .x(lv[l][3*g]),
                .y(lv[l][3*g+1]),
                .z(lv[l][3*g+2]),
                .s(lv[l+1][2*g]),
                .c(lv[l+1][2*g+1])
            );
        end
        for (genvar r = 0; r < R; r++) begin : g_pass
            assign lv[l+1][2*G+r] = lv[l][3*G+r];
        end
        for (genvar e = 2*G+R; e < NIN; e++) begin : g_zero
            assign lv[l+1][e] = '0;
        end
    end

    assign rows_out = lv[LEVELS][NOUT-1:0];
endmodule

// File: rtl/booth_csa_mul.sv
module booth_csa_mul
    import bcm_pkg::*;
#(
    parameter int OPW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [OPW-1:0]   in_a,
    input  logic [OPW-1:0]   in_b,
    output logic             out_valid,
    output logic [2*OPW-1:0] out_sum,
    output logic [2*OPW-1:0] out_carry,
    output logic [2*OPW-1:0] out_product
);
    localparam int PW    = 2 * OPW;
    localparam int NROWS = OPW / 2 + 1;
    localparam int NLVL  = levels_to_two(NROWS);
    localparam int LVL_A = (NLVL + 1) / 2;
    localparam int LVL_B = NLVL - LVL_A;
    localparam int NMID  = rows_at(NROWS, LVL_A);

    // Stage 1: Booth partial products
    logic [NROWS-1:0][PW-1:0] pp_c, pp_q;
    logic                     v1_q;

    booth_pp_gen #(.OPW(OPW)) u_pp (
        .a   (in_a),
        .b   (in_b),
        .rows(pp_c)
    );

    // Stage 2: first half of compressor tree
    logic [NMID-1:0][PW-1:0] mid_c, mid_q;
    logic                    v2_q;

    csa_reduce #(.W(PW), .NIN(NROWS), .LEVELS(LVL_A)) u_red_a (
        .rows_in (pp_q),
        .rows_out(mid_c)
    );

    // Stage 3: second half down to sum/carry
    logic [1:0][PW-1:0] fin_c;
    logic               v3_q;

    csa_reduce #(.W(PW), .NIN(NMID), .LEVELS(LVL_B)) u_red_b (
        .rows_in (mid_q),
        .rows_out(fin_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            v1_q <= 1'b0;
            v2_q <= 1'b0;
            v3_q <= 1'b0;
        end else begin
            v1_q <= in_valid;
            v2_q <= v1_q;
            v3_q <= v2_q;
        end
    end

    always_ff @(posedge clk) begin
        pp_q      <= pp_c;
        mid_q     <= mid_c;
        out_sum   <= fin_c[0];
        out_carry <= fin_c[1];
    end

    assign out_valid   = v3_q;
    assign out_product = out_sum + out_carry;
endmodule

// File: rtl/booth_csa_mul_chk.sv
module booth_csa_mul_chk #(
    parameter int OPW = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [OPW-1:0]   in_a,
    input logic [OPW-1:0]   in_b,
    input logic             out_valid,
    input logic [2*OPW-1:0] out_sum,
    input logic [2*OPW-1:0] out_carry,
    input logic [2*OPW-1:0] out_product
);
    localparam logic [OPW-1:0]   MINV = {1'b1, {(OPW-1){1'b0}}};
    localparam logic [2*OPW-1:0] MINSQ = {2'b01, {(2*OPW-2){1'b0}}};

    logic [2*OPW-1:0] ea, eb, exp_p;
    always_comb begin
        ea    = {{OPW{in_a[OPW-1]}}, in_a};
        eb    = {{OPW{in_b[OPW-1]}}, in_b};
        exp_p = ea * eb;
    end

    AST_PRODUCT_EXACT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_sum + out_carry) == $past(exp_p, 3)); // R1

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##3 out_valid); // R2

    AST_IDLE_LATENCY: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> ##3 !out_valid); // R2

    AST_RESET_CLEARS: assert property (@(posedge clk)
        $past(rst) |-> !out_valid); // R4

    AST_MIN_SQUARE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(in_a, 3) == MINV && $past(in_b, 3) == MINV)
        |-> (out_sum + out_carry) == MINSQ); // R6

    AST_CHECK_OUT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_product == $past(exp_p, 3)); // R8
endmodule

bind booth_csa_mul booth_csa_mul_chk #(.OPW(OPW)) u_chk (.*);

// File: tb/sim_booth_csa_mul.sv
`timescale 1ns/1ps
module sim_booth_csa_mul;
    localparam int OPW = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_a = '0;
    logic [15:0] in_b = '0;
    logic        out_valid;
    logic [31:0] out_sum, out_carry, out_product;

    booth_csa_mul #(.OPW(OPW)) u0 (.*);

    always #4 clk = ~clk; // 125 MHz

    typedef struct {
        logic [31:0] prod;
        int          cyc;
        string       req;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_bad = 0;
    logic [31:0] lfsr = 32'h1BADF00D;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        logic [31:0] x;
        x = s ^ (s << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic send(input logic [15:0] a, input logic [15:0] b, input string req);
        int sa;
        int sb;
        exp_t e;
        @(negedge clk);
        in_a = a;
        in_b = b;
        in_valid = 1'b1;
        sa = $signed(a);
        sb = $signed(b);
        e.prod = sa * sb;
        e.cyc  = cyc + 3;
        e.req  = req;
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_a = 16'hDEAD;
            in_b = 16'hBEEF;
        end
    endtask

    // Monitor / scoreboard
    always @(posedge clk) begin
        #1;
        if (!rst) begin
            if (out_valid) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R2", "unexpected out_valid", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(cyc == e.cyc, "R2", "arrival cycle", cyc, e.cyc);
                    chk(out_sum + out_carry == e.prod, e.req, "sum+carry",
                        out_sum + out_carry, e.prod);
                    chk(out_product == e.prod, "R8", "out_product",
                        out_product, e.prod);
                end
            end else if (q.size() > 0 && q[0].cyc <= cyc) begin
                exp_t e;
                e = q.pop_front();
                chk(1'b0, "R2", "missing out_valid", cyc, e.cyc);
            end
        end
    end

    initial begin
        // R4: valid offered during reset must be dropped
        in_valid = 1'b1;
        in_a = 16'h1234;
        in_b = 16'h0005;
        repeat (4) @(negedge clk);
        chk(out_valid == 1'b0, "R4", "out_valid during reset", out_valid, 0);
        rst = 1'b0;
        in_valid = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R4", "out_valid after reset", out_valid, 0);
        end

        // Corners
        send(16'h8000, 16'h8000, "R6");
        send(16'h8000, 16'h0001, "R7");
        send(16'h0000, 16'h8000, "R9");
        send(16'h7FFF, 16'h0000, "R9");
        idle(2);
        send(16'h7FFF, 16'h7FFF, "R1");
        send(16'hFFFF, 16'hFFFF, "R5");
        send(16'h1234, 16'hFFFF, "R5");
        send(16'h5A5A, 16'h5555, "R5");
        send(16'hC3A1, 16'hAAAA, "R5");
        send(16'h8001, 16'h0003, "R5");
        send(16'h7FFF, 16'h8000, "R1");
        send(16'h8000, 16'h7FFF, "R1");
        idle(5);

        // R3: long back-to-back stream
        for (int i = 0; i < 150; i++) begin
            lfsr = next_rand(lfsr);
            send(lfsr[15:0], lfsr[31:16], "R3");
        end
        // R2: stream with gaps
        for (int i = 0; i < 150; i++) begin
            lfsr = next_rand(lfsr);
            if (lfsr[3:2] == 2'b00) idle(int'(lfsr[5:4]) + 1);
            send(lfsr[31:16], lfsr[15:0], "R1");
        end
        idle(8);
        chk(q.size() == 0, "R2", "results outstanding", q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R2 watchdog expired: actual %0d expected %0d", cyc, 0);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end
endmodule